// File: doc/BRIEF.md
# Snooping Write-Back Queue

This block sits between an on-chip cache and the system bus and holds the memory traffic that is waiting for the bus. It has three sector-wide write entries and a two-deep read queue. One write entry is kept only for a modified sector that the cache must copy back because another bus master snooped it. The other two entries take ordinary stores and sectors evicted by replacement. Every cycle the block picks one request to present on a valid/ready bus port.

Snoop addresses from the bus are compared with the sector entries that are already queued. A hit means memory is stale until that entry is written. The block raises a retry output toward the snooping master until the entry has been accepted by the bus. A hit also moves the entry ahead of reads. Single-beat store entries are never compared against snoops.

A read whose sector address matches any queued write is held back until that write has left. This keeps a load from seeing stale memory.

Top module: `snoop_wbq`

## Requirements
- R1: After reset, `bus_valid`, `snp_retry` and `rd_full` are 0, and `wr_full` is 0 for a store.
- R2: A write with `wr_kind` 1 (single-beat store) or 2 (cast-out sector) takes a free general entry. There are two general entries. While both hold data, `wr_full` is 1 for kinds 1 and 2 and the write is dropped.
- R3: A write with `wr_kind` 3 (snoop push) goes only to the reserved entry. While that entry is occupied, `wr_full` is 1 for kind 3. `wr_full` is always 1 for kind 0.
- R4: While the reserved snoop-push entry is occupied, it is the request on the bus, with `bus_kind` 3.
- R5: If a snoop matches the address of a queued cast-out or push entry that is not leaving in that cycle, `snp_retry` is 1 from the next cycle on. It returns to 0 in the cycle after the last such entry is accepted by the bus.
- R6: A snoop that matches only single-beat store entries leaves `snp_retry` at 0.
- R7: A general entry hit by a snoop is issued before any read and before any general write that has not been snooped.
- R8: A read that is not blocked under R9 is issued before general writes that have not been snooped.
- R9: A read whose sector address equals the address of any queued write is not issued until that write has been accepted.
- R10: General writes that have not been snooped leave in arrival order.
- R11: The read queue holds two requests and issues them in arrival order. While it holds two, `rd_full` is 1 and a new read is dropped.
- R12: A request stays queued, and `bus_valid` stays 1, until a cycle in which `bus_valid` and `bus_ready` are both 1. `bus_kind` is 0 for read, 1 for store, 2 for cast-out and 3 for snoop push. `bus_data` carries the entry's sector for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write enqueue request |
| wr_kind | input | 2 | Write kind: 1 store, 2 cast-out, 3 snoop push |
| wr_addr | input | ADDR_W | Sector address of the write |
| wr_data | input | WORD_W*WORDS | Sector data of the write |
| wr_full | output | 1 | No suitable write entry free for `wr_kind` |
| rd_valid | input | 1 | Read enqueue request |
| rd_addr | input | ADDR_W | Sector address of the read |
| rd_full | output | 1 | Read queue full |
| snp_valid | input | 1 | Snoop address valid |
| snp_addr | input | ADDR_W | Snooped sector address |
| snp_retry | output | 1 | A snooped queued sector is still waiting for the bus |
| bus_valid | output | 1 | A request is offered to the bus |
| bus_ready | input | 1 | Bus accepts the offered request |
| bus_kind | output | 2 | Kind of the offered request |
| bus_addr | output | ADDR_W | Sector address of the offered request |
| bus_data | output | WORD_W*WORDS | Sector data of the offered write |

## Verification
The embedded properties watch, on every cycle, that at most one request is granted and that an occupied push entry always owns the bus. They also check that a granted read never overlaps a queued write address, that a stalled offer stays valid, that a store entry never carries a snoop mark, and that a snoop hit raises retry in the next cycle. Some behaviour only shows over a sequence of cycles, and only the bench's scenarios can show it. This covers arrival order among writes, the exact cycle at which retry drops after the hit entry leaves, refusal once the entries fill, and the data delivered with each write. The bench measures these against a queue model of its own, driven by mixed random and directed traffic.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_CAST  = 2'd2,
      KIND_PUSH  = 2'd3
   } wbq_kind_e;
endpackage

// File: rtl/wbq_wslot.sv
module wbq_wslot
   import wbq_pkg::*;
#(
   parameter int ADDR_W = 27,
   parameter int DATA_W = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        load_kind,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   input  logic              pop,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              valid,
   output logic              snooped,
   output logic [1:0]        kind,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   logic              valid_q, snp_q;
   logic [1:0]        kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              snp_match;

   // single-beat stores are never compared
   assign snp_match = snp_valid && valid_q && (kind_q != KIND_STORE) && (addr_q == snp_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         snp_q   <= 1'b0;
      end else if (pop) begin
         valid_q <= 1'b0;
         snp_q   <= 1'b0;
      end else if (load) begin
         valid_q <= 1'b1;
         snp_q   <= 1'b0;
      end else if (snp_match) begin
         snp_q   <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         kind_q <= load_kind;
         addr_q <= load_addr;
         data_q <= load_data;
      end
   end

   assign valid   = valid_q;
   assign snooped = snp_q;
   assign kind    = kind_q;
   assign addr    = addr_q;
   assign data    = data_q;

   // R2
   load_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !valid_q);

   // R6
   store_unsnooped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && kind_q == KIND_STORE) |-> !snp_q);
endmodule

// File: rtl/wbq_rdfifo.sv
module wbq_rdfifo #(
   parameter int ADDR_W = 27,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic              empty,
   output logic              full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [ADDR_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  cnt;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= nxt(wr_ptr);
         if (pop)  rd_ptr <= nxt(rd_ptr);
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_addr;
   end

   assign head_addr = mem[rd_ptr];
   assign empty     = (cnt == '0);
   assign full      = (cnt == CNT_W'(DEPTH));

   // R11
   rd_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);

   // R11
   rd_udf_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/wbq_pick.sv
module wbq_pick #(
   parameter int NGEN = 2
) (
   input  logic            push_v,
   input  logic [NGEN-1:0] gen_v,
   input  logic [NGEN-1:0] gen_snp,
   input  logic [NGEN-1:0] older [NGEN],
   input  logic            rd_v,
   input  logic            rd_blk,
   output logic            gnt_push,
   output logic [NGEN-1:0] gnt_gen,
   output logic            gnt_rd
);
   logic [NGEN-1:0] snp_set, cand, oldest;
   logic            beaten;

   always_comb begin
      snp_set = gen_v & gen_snp;
      cand    = (|snp_set) ? snp_set : gen_v;
      oldest  = '0;
      beaten  = 1'b0;
      for (int i = 0; i < NGEN; i++) begin
         beaten = 1'b0;
         for (int j = 0; j < NGEN; j++) begin
            if (cand[j] && older[j][i]) beaten = 1'b1;
         end
         oldest[i] = cand[i] && !beaten;
      end
      gnt_push = push_v;
      gnt_rd   = !push_v && !(|snp_set) && rd_v && !rd_blk;
      gnt_gen  = (push_v || gnt_rd) ? '0 : oldest;
   end
endmodule

// File: rtl/snoop_wbq.sv
module snoop_wbq
   import wbq_pkg::*;
#(
   parameter int ADDR_W    = 27,
   parameter int WORD_W    = 32,
   parameter int WORDS     = 8,
   parameter int GEN_SLOTS = 2,
   parameter int RD_DEPTH  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_valid,
   input  logic [1:0]                wr_kind,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [WORD_W*WORDS-1:0]   wr_data,
   output logic                      wr_full,
   input  logic                      rd_valid,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic                      rd_full,
   input  logic                      snp_valid,
   input  logic [ADDR_W-1:0]         snp_addr,
   output logic                      snp_retry,
   output logic                      bus_valid,
   input  logic                      bus_ready,
   output logic [1:0]                bus_kind,
   output logic [ADDR_W-1:0]         bus_addr,
   output logic [WORD_W*WORDS-1:0]   bus_data
);
   localparam int DATA_W = WORD_W * WORDS;
   localparam int NSLOT  = GEN_SLOTS + 1;

   if (ADDR_W < 1 || WORD_W < 1 || WORDS < 1) begin : g_bad_width
      $error("snoop_wbq: widths must be positive");
   end
   if (GEN_SLOTS < 1) begin : g_bad_gen
      $error("snoop_wbq: at least one general write entry");
   end
   if (RD_DEPTH < 2) begin : g_bad_rd
      $error("snoop_wbq: read queue depth below 2");
   end

   logic [NSLOT-1:0]     s_valid, s_snp, s_load, s_pop, s_gnt;
   logic [1:0]           s_kind [NSLOT];
   logic [ADDR_W-1:0]    s_addr [NSLOT];
   logic [DATA_W-1:0]    s_data [NSLOT];
   logic [GEN_SLOTS-1:0] gen_v, gen_snp, gen_free_oh, gnt_gen;
   logic [GEN_SLOTS-1:0] older_q [GEN_SLOTS];
   logic                 found, wr_take, gnt_push, gnt_rd, fire, rd_pop;
   logic                 rd_empty, rd_blk, snp_hit_stay;
   logic [ADDR_W-1:0]    rd_head;

   assign gen_v   = s_valid[NSLOT-1:1];
   assign gen_snp = s_snp[NSLOT-1:1];

   always_comb begin
      gen_free_oh = '0;
      found       = 1'b0;
      for (int g = 0; g < GEN_SLOTS; g++) begin
         if (!gen_v[g] && !found) begin
            gen_free_oh[g] = 1'b1;
            found          = 1'b1;
         end
      end
      case (wr_kind)
         KIND_PUSH:            wr_full = s_valid[0];
         KIND_STORE, KIND_CAST: wr_full = !found;
         default:              wr_full = 1'b1;
      endcase
      wr_take = wr_valid && !wr_full;
      s_load  = '0;
      if (wr_take) begin
         if (wr_kind == KIND_PUSH) s_load[0] = 1'b1;
         else                      s_load[NSLOT-1:1] = gen_free_oh;
      end
   end

   // arrival order among general entries: older_q[j][i] set when j came before i
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < GEN_SLOTS; j++) older_q[j] <= '0;
      end else begin
         for (int j = 0; j < GEN_SLOTS; j++) begin
            for (int i = 0; i < GEN_SLOTS; i++) begin
               if (s_load[i+1])      older_q[j][i] <= gen_v[j];
               else if (s_load[j+1]) older_q[j][i] <= 1'b0;
            end
         end
      end
   end

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      wbq_wslot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (s_load[k]),
         .load_kind ((k == 0) ? 2'(KIND_PUSH) : wr_kind),
         .load_addr (wr_addr),
         .load_data (wr_data),
         .pop       (s_pop[k]),
         .snp_valid (snp_valid),
         .snp_addr  (snp_addr),
         .valid     (s_valid[k]),
         .snooped   (s_snp[k]),
         .kind      (s_kind[k]),
         .addr      (s_addr[k]),
         .data      (s_data[k])
      );
   end

   wbq_rdfifo #(.ADDR_W(ADDR_W), .DEPTH(RD_DEPTH)) u_rdq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rd_valid && !rd_full),
      .push_addr (rd_addr),
      .pop       (rd_pop),
      .head_addr (rd_head),
      .empty     (rd_empty),
      .full      (rd_full)
   );

   always_comb begin
      rd_blk       = 1'b0;
      snp_hit_stay = 1'b0;
      for (int k = 0; k < NSLOT; k++) begin
         if (s_valid[k] && s_addr[k] == rd_head) rd_blk = 1'b1;
         if (s_valid[k] && !s_pop[k] && s_kind[k] != KIND_STORE && s_addr[k] == snp_addr)
            snp_hit_stay = 1'b1;
      end
   end

   wbq_pick #(.NGEN(GEN_SLOTS)) u_pick (
      .push_v   (s_valid[0]),
      .gen_v    (gen_v),
      .gen_snp  (gen_snp),
      .older    (older_q),
      .rd_v     (!rd_empty),
      .rd_blk   (rd_blk),
      .gnt_push (gnt_push),
      .gnt_gen  (gnt_gen),
      .gnt_rd   (gnt_rd)
   );

   assign s_gnt     = {gnt_gen, gnt_push};
   assign bus_valid = (|s_gnt) || gnt_rd;
   assign fire      = bus_valid && bus_ready;
   assign s_pop     = fire ? s_gnt : '0;
   assign rd_pop    = fire && gnt_rd;
   assign snp_retry = |(s_valid & s_snp);

   always_comb begin
      bus_kind = KIND_READ;
      bus_addr = rd_head;
      bus_data = '0;
      for (int k = 0; k < NSLOT; k++) begin
         if (s_gnt[k]) begin
            bus_kind = s_kind[k];
            bus_addr = s_addr[k];
            bus_data = s_data[k];
         end
      end
   end

   // R4
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_rd, s_gnt}));

   // R4
   push_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid[0] |-> (bus_valid && bus_kind == KIND_PUSH));

   // R5
   retry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_hit_stay) |=> snp_retry);

   // R7
   snooped_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gen_v & gen_snp)) |-> (bus_valid && bus_kind != KIND_READ));

   // R9
   rd_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_kind == KIND_READ) |-> !rd_blk);

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> bus_valid);
endmodule

// File: tb/tb_snoop_wbq.sv
module tb_snoop_wbq;
   localparam int AW = 27;
   localparam int DW = 256;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_valid, rd_valid, snp_valid, bus_ready;
   logic [1:0]    wr_kind;
   logic [AW-1:0] wr_addr, rd_addr, snp_addr;
   logic [DW-1:0] wr_data;
   logic          wr_full, rd_full, snp_retry, bus_valid;
   logic [1:0]    bus_kind;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;

   always #2 clk = ~clk;

   snoop_wbq dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data), .wr_full(wr_full),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_full(rd_full),
      .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_retry(snp_retry),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_kind(bus_kind),
      .bus_addr(bus_addr), .bus_data(bus_data)
   );

   int checks = 0;
   int errors = 0;

   // queue model: slot 0 reserved, 1..2 general
   bit            mv [3];
   bit            mp [3];
   logic [1:0]    mk [3];
   logic [AW-1:0] ma [3];
   logic [DW-1:0] md [3];
   int            ms [3];
   int            seqc = 0;
   logic [AW-1:0] rq [2];
   int            rn = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit rd_blocked();
      for (int k = 0; k < 3; k++)
         if (rn > 0 && mv[k] && ma[k] == rq[0]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int oldest_gen(input bit only_snooped);
      int best = -1;
      for (int k = 1; k < 3; k++)
         if (mv[k] && (!only_snooped || mp[k]) && (best < 0 || ms[k] < ms[best])) best = k;
      return best;
   endfunction

   function automatic int mpick();
      int s;
      if (mv[0]) return 0;
      s = oldest_gen(1'b1);
      if (s >= 0) return s;
      if (rn > 0 && !rd_blocked()) return 3;
      return oldest_gen(1'b0);
   endfunction

   function automatic string mtag(input int g);
      if (g < 0) return "R12";
      if (g == 0) return "R4";
      if (g == 3) return "R8";
      if (mp[g]) return "R7";
      if (rn > 0) return "R9";
      return "R10";
   endfunction

   task automatic idle();
      wr_valid = 0; wr_kind = 0; wr_addr = '0; wr_data = '0;
      rd_valid = 0; rd_addr = '0; snp_valid = 0; snp_addr = '0; bus_ready = 0;
   endtask

   task automatic look();
      @(negedge clk);
      #1;
   endtask

   task automatic step(input bit wv, input logic [1:0] wk, input logic [AW-1:0] wa,
                       input bit rv, input logic [AW-1:0] ra,
                       input bit sv, input logic [AW-1:0] sa, input bit rdy);
      logic [DW-1:0] wd;
      logic [1:0]    ekind;
      logic [AW-1:0] eaddr;
      int            g, freeg, slot;
      bit            ewf, erf, eret, fire;
      for (int w = 0; w < 8; w++) wd[w*32 +: 32] = $urandom;
      @(negedge clk);
      wr_valid = wv; wr_kind = wk; wr_addr = wa; wr_data = wd;
      rd_valid = rv; rd_addr = ra; snp_valid = sv; snp_addr = sa; bus_ready = rdy;
      #1;
      freeg = -1;
      for (int k = 2; k > 0; k--) if (!mv[k]) freeg = k;
      ewf = (wk == 2'd3) ? mv[0] : ((wk == 2'd1 || wk == 2'd2) ? (freeg < 0) : 1'b1);
      chk(wr_full == ewf, (wk == 2'd3 || wk == 2'd0) ? "R3" : "R2", "wr_full", wr_full, ewf);
      erf = (rn == 2);
      chk(rd_full == erf, "R11", "rd_full", rd_full, erf);
      eret = (mv[0] && mp[0]) || (mv[1] && mp[1]) || (mv[2] && mp[2]);
      chk(snp_retry == eret, "R5", "snp_retry", snp_retry, eret);
      g = mpick();
      chk(bus_valid == (g >= 0), mtag(g), "bus_valid", bus_valid, g >= 0);
      if (g >= 0 && bus_valid) begin
         ekind = (g == 3) ? 2'd0 : mk[g];
         eaddr = (g == 3) ? rq[0] : ma[g];
         chk(bus_kind == ekind, mtag(g), "bus_kind", bus_kind, ekind);
         chk(bus_addr == eaddr, mtag(g), "bus_addr", bus_addr, eaddr);
         if (g != 3)
            chk(bus_data == md[g], "R12", "bus_data", bus_data[31:0], md[g][31:0]);
      end
      fire = (g >= 0) && rdy;
      @(posedge clk);
      if (fire) begin
         if (g == 3) begin
            rq[0] = rq[1];
            rn--;
         end else begin
            mv[g] = 0;
            mp[g] = 0;
         end
      end
      if (sv)
         for (int k = 0; k < 3; k++)
            if (mv[k] && mk[k] != 2'd1 && ma[k] == sa) mp[k] = 1;
      if (wv && !ewf) begin
         slot = (wk == 2'd3) ? 0 : freeg;
         mv[slot] = 1; mp[slot] = 0; mk[slot] = wk; ma[slot] = wa; md[slot] = wd;
         ms[slot] = seqc++;
      end
      if (rv && !erf) begin
         rq[rn] = ra;
         rn++;
      end
      #1;
      idle();
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < 3; k++) begin mv[k] = 0; mp[k] = 0; end
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R1 reset state
      look();
      chk(bus_valid == 0, "R1", "bus_valid", bus_valid, 0);
      chk(snp_retry == 0, "R1", "snp_retry", snp_retry, 0);
      chk(rd_full == 0, "R1", "rd_full", rd_full, 0);
      wr_kind = 2'd1; #1;
      chk(wr_full == 0, "R1", "wr_full", wr_full, 0);
      idle();

      // R6 store not snooped, R5 and R7 on a snooped cast-out
      step(1, 2'd1, 5, 0, 0, 0, 0, 0);
      step(0, 2'd0, 0, 0, 0, 1, 5, 0);
      look();
      chk(snp_retry == 0, "R6", "snp_retry", snp_retry, 0);
      step(1, 2'd2, 6, 0, 0, 0, 0, 0);
      step(0, 2'd0, 0, 0, 0, 1, 6, 0);
      look();
      chk(snp_retry == 1, "R5", "snp_retry", snp_retry, 1);
      chk(bus_kind == 2'd2, "R7", "bus_kind", bus_kind, 2);
      wr_kind = 2'd1; #1;
      chk(wr_full == 1, "R2", "wr_full", wr_full, 1);
      wr_kind = 2'd3; #1;
      chk(wr_full == 0, "R3", "wr_full", wr_full, 0);
      idle();
      step(1, 2'd3, 5, 0, 0, 0, 0, 0);
      look();
      chk(bus_kind == 2'd3, "R4", "bus_kind", bus_kind, 3);
      wr_kind = 2'd3; #1;
      chk(wr_full == 1, "R3", "wr_full", wr_full, 1);
      idle();
      step(0, 2'd0, 0, 0, 0, 0, 0, 1);
      look();
      chk(bus_kind == 2'd2, "R7", "bus_kind", bus_kind, 2);
      chk(snp_retry == 1, "R5", "snp_retry", snp_retry, 1);
      step(0, 2'd0, 0, 0, 0, 0, 0, 1);
      look();
      chk(snp_retry == 0, "R5", "snp_retry", snp_retry, 0);
      chk(bus_kind == 2'd1, "R10", "bus_kind", bus_kind, 1);
      step(0, 2'd0, 0, 0, 0, 0, 0, 1);

      // R9 hazard, R11 depth and order, R8 read first
      step(1, 2'd2, 7, 0, 0, 0, 0, 0);
      step(0, 2'd0, 0, 1, 7, 0, 0, 0);
      step(0, 2'd0, 0, 1, 8, 0, 0, 0);
      step(0, 2'd0, 0, 1, 9, 0, 0, 0);
      look();
      chk(rd_full == 1, "R11", "rd_full", rd_full, 1);
      chk(bus_kind == 2'd2 && bus_addr == 7, "R9", "bus_addr", bus_addr, 7);
      step(0, 2'd0, 0, 0, 0, 0, 0, 1);
      look();
      chk(bus_kind == 2'd0 && bus_addr == 7, "R11", "bus_addr", bus_addr, 7);
      step(0, 2'd0, 0, 0, 0, 0, 0, 1);
      step(1, 2'd1, 11, 0, 0, 0, 0, 0);
      look();
      chk(bus_kind == 2'd0 && bus_addr == 8, "R8", "bus_addr", bus_addr, 8);
      step(0, 2'd0, 0, 0, 0, 0, 0, 1);
      step(1, 2'd1, 12, 0, 0, 0, 0, 0);
      step(0, 2'd0, 0, 0, 0, 0, 0, 1);
      look();
      chk(bus_kind == 2'd1 && bus_addr == 12, "R10", "bus_addr", bus_addr, 12);
      step(0, 2'd0, 0, 0, 0, 0, 0, 1);

      // constrained random traffic over a small address range
      for (int n = 0; n < 4000; n++) begin
         step($urandom % 2 == 0, 2'($urandom % 4), AW'($urandom % 4),
              $urandom % 3 == 0, AW'($urandom % 4),
              $urandom % 4 == 0, AW'($urandom % 4),
              $urandom % 2 == 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule